// File: doc/BRIEF.md
# Isolated I/O Port Decoder

This block sits beside a processor bus that carries a separate I/O address space and a 16-bit data path split into a low and a high byte bank. It watches each bus cycle's memory/IO select and write/read pins and forms an I/O read or I/O write command from them. It compares the 16-bit port address with a base set by a parameter. It then either strobes a bank of byte latches that hold output data, or opens a gated path that places one input word on the read bus.

The decoded window covers `NUM_PORTS` word ports, starting at the even address `BASE_ADDR`. Port `k` sits at `BASE_ADDR + 2k`. Writes honour the two byte-bank enables, so a single byte can be updated without disturbing its neighbour. Reads do not look at the bank enables: one output-enable presents the whole 16-bit word, and the processor keeps the byte it wants. Because the chip has no internal tri-states, the input path is modelled as a data word plus an output-enable flag. The data word is zero whenever the flag is low.

Top module: `io_port_decoder`

## Requirements
- R1: Only `addr[15:0]` takes part in decoding. Bits of `addr` above bit 15 never change a strobe, `rd_oe` or `rd_data`.
- R2: A command exists only when `cyc_act` is 1 and `mem_sel` is 0. A write command also needs `wr_sel` = 1, and a read command needs `wr_sel` = 0. A memory cycle or an idle bus gives no strobe and no `rd_oe`.
- R3: An I/O write with `addr[0]` = 0 and `hi_bank_n` = 1 asserts only `wr_stb_lo[k]` for the addressed port `k`. Only bits 7:0 of that port's latch take the value of `wdata[7:0]`.
- R4: An I/O write with `addr[0]` = 1 and `hi_bank_n` = 0 asserts only `wr_stb_hi[k]`. Only bits 15:8 of that port's latch take the value of `wdata[15:8]`.
- R5: An I/O write with `addr[0]` = 0 and `hi_bank_n` = 0 asserts `wr_stb_lo[k]` and `wr_stb_hi[k]` in the same cycle, and the whole word is captured. If `addr[0]` = 1 and `hi_bank_n` = 1, no strobe is asserted.
- R6: A latch byte loads on the rising clock edge where its strobe is high and shows the new value right after that edge. It keeps its value until its own strobe is high again.
- R7: An in-range I/O read asserts `rd_oe` in the same cycle, whatever the state of `addr[0]` and `hi_bank_n`. In that cycle `rd_data` equals word `k` of `in_ports`, which is bits `16k+15:16k`.
- R8: Whenever `rd_oe` is 0, `rd_data` is all zeros.
- R9: If `addr[15:0]` lies below `BASE_ADDR` or at or above `BASE_ADDR + 2*NUM_PORTS`, no strobe and no `rd_oe` is produced.
- R10: A synchronous reset (`rst_n` low at a clock edge) clears every output latch to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_act | input | 1 | A bus cycle is in its command phase |
| mem_sel | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| wr_sel | input | 1 | 1 = write, 0 = read |
| addr | input | BUS_ADDR_W | Bus address; only bits 15:0 are decoded |
| hi_bank_n | input | 1 | Active-low high byte-bank enable |
| wdata | input | 16 | Write data from the processor |
| wr_stb_lo | output | NUM_PORTS | Low-bank latch strobe for each port |
| wr_stb_hi | output | NUM_PORTS | High-bank latch strobe for each port |
| out_ports | output | 16*NUM_PORTS | Latched output words; port k at bits 16k+15:16k |
| in_ports | input | 16*NUM_PORTS | Input words from devices; port k at bits 16k+15:16k |
| rd_oe | output | 1 | Input path is driving the read bus |
| rd_data | output | 16 | Gated input word; zero when rd_oe is low |

## Verification
The hardest situation to reach is a partial write that lands between two earlier writes to the same port. In that case the byte that is not addressed must survive while its neighbour changes. Proving this needs the full history of every latch byte, not just one write and one readback. The bench sweeps every port through all four combinations of `addr[0]` and `hi_bank_n`, each with fresh data and varied upper address bits. After every edge it compares all latched words with an arithmetic model, so any byte disturbed by an earlier write shows up at once. Reads and writes are also swept just below, across and just above the decoded window. This covers the boundary comparisons and checks that the bank enables make no difference to reads.

// File: rtl/io_dec_pkg.sv
// Shared constants and types for the isolated I/O port decoder.
// Assumes a 16-bit data path made of two byte banks and a 16-bit I/O space.
package io_dec_pkg;
    localparam int BANK_W    = 8;
    localparam int NUM_BANKS = 2;
    localparam int WORD_W    = BANK_W * NUM_BANKS;
    localparam int DEC_W     = 16;

    typedef enum logic [1:0] {
        CMD_IDLE = 2'd0,
        CMD_RD   = 2'd1,
        CMD_WR   = 2'd2
    } io_cmd_e;
endpackage

// File: rtl/io_cmd_gen.sv
// Forms the I/O command from the bus qualifier and the memory/IO and
// write/read pins. Assumes the pins are stable while cyc_act is high.
module io_cmd_gen
    import io_dec_pkg::*;
(
    input  logic    cyc_act,
    input  logic    mem_sel,
    input  logic    wr_sel,
    output io_cmd_e cmd
);
    // Decode the cycle type; memory cycles never become I/O commands.
    always_comb begin
        cmd = CMD_IDLE;
        if (cyc_act && !mem_sel) begin
            cmd = wr_sel ? CMD_WR : CMD_RD;
        end
    end
endmodule

// File: rtl/io_addr_match.sv
// Compares the 16-bit port address with the decoded window and returns
// the word-port index. Assumes BASE_ADDR is even; bit 0 picks a bank.
module io_addr_match
    import io_dec_pkg::*;
#(
    parameter logic [DEC_W-1:0] BASE_ADDR = 16'h0300,
    parameter int               NUM_PORTS = 4,
    parameter int               IDX_W     = 2
) (
    input  logic [DEC_W-1:0] port_addr,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    localparam logic [DEC_W:0] SPAN = (DEC_W+1)'(2 * NUM_PORTS);

    logic [DEC_W:0] offset;
    logic           unused_off;

    // Offset from the base, one bit wider so a borrow marks "below base".
    always_comb begin
        offset = {1'b0, port_addr} - {1'b0, BASE_ADDR};
        hit    = !offset[DEC_W] && (offset < SPAN);
        idx    = offset[IDX_W:1];
    end

    assign unused_off = ^{offset[DEC_W-1:IDX_W+1], offset[0]};
endmodule

// File: rtl/io_bank_strobe.sv
// Builds the low and high byte-bank latch strobes for each port from the
// write command, the address hit, bank-select bit 0 and the high-bank enable.
module io_bank_strobe #(
    parameter int NUM_PORTS = 4,
    parameter int IDX_W     = 2
) (
    input  logic                 wr_cmd,
    input  logic                 hit,
    input  logic [IDX_W-1:0]     idx,
    input  logic                 a0,
    input  logic                 hi_bank_n,
    output logic [NUM_PORTS-1:0] stb_lo,
    output logic [NUM_PORTS-1:0] stb_hi
);
    logic go;

    // A strobe is only possible for a decoded I/O write.
    assign go = wr_cmd && hit;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic sel;
        // Port select from the word index.
        assign sel       = go && (idx == IDX_W'(p));
        // Low bank enabled by even address, high bank by its own enable.
        assign stb_lo[p] = sel && !a0;
        assign stb_hi[p] = sel && !hi_bank_n;
    end
endmodule

// File: rtl/io_byte_latch.sv
// One byte of an output port: loads on the clock edge where its strobe
// is high and holds otherwise. Synchronous active-low reset to zero.
module io_byte_latch
    import io_dec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BANK_W-1:0] d,
    output logic [BANK_W-1:0] q
);
    // Capture bus data on the strobe; keep it until the next strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end
endmodule

// File: rtl/io_in_gate.sv
// Gated input path standing in for tri-state buffers: a single enable
// presents the selected input word; otherwise the word is forced to zero.
module io_in_gate
    import io_dec_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int IDX_W     = 2
) (
    input  logic                        rd_cmd,
    input  logic                        hit,
    input  logic [IDX_W-1:0]            idx,
    input  logic [NUM_PORTS*WORD_W-1:0] in_ports,
    output logic                        rd_oe,
    output logic [WORD_W-1:0]           rd_data
);
    // One enable for the whole word; bank enables are not consulted.
    assign rd_oe = rd_cmd && hit;

    // Select the indexed word only while enabled.
    always_comb begin
        rd_data = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (rd_oe && (idx == IDX_W'(p))) begin
                rd_data = in_ports[p*WORD_W +: WORD_W];
            end
        end
    end
endmodule

// File: rtl/io_port_decoder.sv
// Isolated I/O port decoder top. Decodes I/O cycles for NUM_PORTS word
// ports at BASE_ADDR, strobes byte-bank output latches on writes and gates
// input words onto the read bus on reads. Assumes BASE_ADDR is even and
// that address bits above bit 15 carry no meaning for I/O cycles.
module io_port_decoder
    import io_dec_pkg::*;
#(
    parameter int               BUS_ADDR_W = 20,
    parameter logic [DEC_W-1:0] BASE_ADDR  = 16'h0300,
    parameter int               NUM_PORTS  = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cyc_act,
    input  logic                        mem_sel,
    input  logic                        wr_sel,
    input  logic [BUS_ADDR_W-1:0]       addr,
    input  logic                        hi_bank_n,
    input  logic [WORD_W-1:0]           wdata,
    output logic [NUM_PORTS-1:0]        wr_stb_lo,
    output logic [NUM_PORTS-1:0]        wr_stb_hi,
    output logic [NUM_PORTS*WORD_W-1:0] out_ports,
    input  logic [NUM_PORTS*WORD_W-1:0] in_ports,
    output logic                        rd_oe,
    output logic [WORD_W-1:0]           rd_data
);
    localparam int IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

    io_cmd_e          cmd;
    logic             hit;
    logic [IDX_W-1:0] idx;
    logic             unused_hi_addr;

    // Upper address bits take no part in I/O decoding.
    assign unused_hi_addr = ^addr[BUS_ADDR_W-1:DEC_W];

    io_cmd_gen u_cmd (
        .cyc_act (cyc_act),
        .mem_sel (mem_sel),
        .wr_sel  (wr_sel),
        .cmd     (cmd)
    );

    io_addr_match #(
        .BASE_ADDR (BASE_ADDR),
        .NUM_PORTS (NUM_PORTS),
        .IDX_W     (IDX_W)
    ) u_match (
        .port_addr (addr[DEC_W-1:0]),
        .hit       (hit),
        .idx       (idx)
    );

    io_bank_strobe #(
        .NUM_PORTS (NUM_PORTS),
        .IDX_W     (IDX_W)
    ) u_stb (
        .wr_cmd    (cmd == CMD_WR),
        .hit       (hit),
        .idx       (idx),
        .a0        (addr[0]),
        .hi_bank_n (hi_bank_n),
        .stb_lo    (wr_stb_lo),
        .stb_hi    (wr_stb_hi)
    );

    io_in_gate #(
        .NUM_PORTS (NUM_PORTS),
        .IDX_W     (IDX_W)
    ) u_in (
        .rd_cmd   (cmd == CMD_RD),
        .hit      (hit),
        .idx      (idx),
        .in_ports (in_ports),
        .rd_oe    (rd_oe),
        .rd_data  (rd_data)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_out
        io_byte_latch u_lo (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (wr_stb_lo[p]),
            .d     (wdata[BANK_W-1:0]),
            .q     (out_ports[p*WORD_W +: BANK_W])
        );
        io_byte_latch u_hi (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (wr_stb_hi[p]),
            .d     (wdata[WORD_W-1:BANK_W]),
            .q     (out_ports[p*WORD_W+BANK_W +: BANK_W])
        );

        // R6
        lo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_stb_lo[p] |=> $stable(out_ports[p*WORD_W +: BANK_W]));
        // R6
        lo_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wr_stb_lo[p] |=> out_ports[p*WORD_W +: BANK_W] == $past(wdata[BANK_W-1:0]));
        // R6
        hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_stb_hi[p] |=> $stable(out_ports[p*WORD_W+BANK_W +: BANK_W]));
    end

    // R2
    wr_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|{wr_stb_lo, wr_stb_hi}) |-> (cyc_act && !mem_sel && wr_sel));
    // R2
    rd_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_oe |-> (cyc_act && !mem_sel && !wr_sel));
    // R3
    lo_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_stb_lo));
    // R4
    hi_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_stb_hi));
    // R5
    word_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_WR && hit && !addr[0] && !hi_bank_n)
            |-> (wr_stb_lo == wr_stb_hi && $countones(wr_stb_lo) == 1));
    // R8
    rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_oe |-> rd_data == '0);
    // R9
    miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (!rd_oe && wr_stb_lo == '0 && wr_stb_hi == '0));
endmodule

// File: tb/io_port_decoder_tb.sv
// Sweeping bench for io_port_decoder: four ports at 0x0300, 20-bit bus.
module io_port_decoder_tb;
    localparam int          NP   = 4;
    localparam int          AW   = 20;
    localparam logic [15:0] BASE = 16'h0300;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              cyc_act, mem_sel, wr_sel, hi_bank_n;
    logic [AW-1:0]     addr;
    logic [15:0]       wdata;
    logic [NP-1:0]     wr_stb_lo, wr_stb_hi;
    logic [NP*16-1:0]  out_ports, in_ports;
    logic              rd_oe;
    logic [15:0]       rd_data;

    int          checks = 0;
    int          errors = 0;
    logic        done   = 1'b0;
    logic [15:0] model [NP];

    io_port_decoder #(.BUS_ADDR_W(AW), .BASE_ADDR(BASE), .NUM_PORTS(NP)) u_dut (
        .clk(clk), .rst_n(rst_n), .cyc_act(cyc_act), .mem_sel(mem_sel),
        .wr_sel(wr_sel), .addr(addr), .hi_bank_n(hi_bank_n), .wdata(wdata),
        .wr_stb_lo(wr_stb_lo), .wr_stb_hi(wr_stb_hi), .out_ports(out_ports),
        .in_ports(in_ports), .rd_oe(rd_oe), .rd_data(rd_data)
    );

    always #4 clk = ~clk;

    function automatic logic [15:0] in_word(input int p);
        return 16'hA191 + 16'(p) * 16'h1122;
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic act, input logic mem, input logic wr,
                         input logic [AW-1:0] a, input logic hn, input logic [15:0] d);
        @(negedge clk);
        cyc_act = act; mem_sel = mem; wr_sel = wr; addr = a; hi_bank_n = hn; wdata = d;
        #1;
    endtask

    // After the next rising edge, compare all latched words with the model.
    task automatic check_latches(input string tag);
        @(posedge clk);
        #1;
        for (int p = 0; p < NP; p++) begin
            chk(out_ports[p*16 +: 16] == model[p], tag, out_ports[p*16 +: 16], model[p]);
        end
    endtask

    task automatic finish_run;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        for (int p = 0; p < NP; p++) begin
            in_ports[p*16 +: 16] = in_word(p);
            model[p] = 16'h0000;
        end
        rst_n = 1'b0;
        cyc_act = 0; mem_sel = 0; wr_sel = 0; addr = '0; hi_bank_n = 1; wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R10 reset state
        chk(out_ports == '0, "R10 reset latches", out_ports, 0);
        chk(rd_oe == 1'b0 && rd_data == 16'h0, "R8 idle read path", {rd_oe, rd_data}, 0);
        chk(wr_stb_lo == '0 && wr_stb_hi == '0, "R2 idle strobes", {wr_stb_lo, wr_stb_hi}, 0);

        // Write sweep: R3 lo byte, R4 hi byte, R5 word / none, R1 upper bits varied.
        for (int rnd = 0; rnd < 2; rnd++) begin
            for (int p = 0; p < NP; p++) begin
                for (int m = 0; m < 4; m++) begin
                    logic        a0, hn, exp_lo, exp_hi;
                    logic [15:0] d;
                    logic [AW-1:0] a;
                    a0 = (m == 1 || m == 3);
                    hn = (m == 0 || m == 3);
                    exp_lo = !a0;
                    exp_hi = !hn;
                    d = 16'(16'h1357 * (rnd * 16 + p * 4 + m + 1));
                    a = {4'(p + m + rnd * 5), BASE + 16'(2 * p) + 16'(a0)};
                    drive(1, 0, 1, a, hn, d);
                    chk(wr_stb_lo == (exp_lo ? NP'(1) << p : NP'(0)),
                        "R3 R5 lo strobe", wr_stb_lo, exp_lo ? NP'(1) << p : NP'(0));
                    chk(wr_stb_hi == (exp_hi ? NP'(1) << p : NP'(0)),
                        "R4 R5 hi strobe", wr_stb_hi, exp_hi ? NP'(1) << p : NP'(0));
                    chk(rd_oe == 1'b0, "R8 no read on write", rd_oe, 0);
                    if (exp_lo) model[p][7:0]  = d[7:0];
                    if (exp_hi) model[p][15:8] = d[15:8];
                    check_latches("R6 latch contents");
                end
            end
        end

        // R2: memory cycles and idle bus in range leave everything alone.
        for (int p = 0; p < NP; p++) begin
            drive(1, 1, 1, {4'h0, BASE + 16'(2 * p)}, 0, 16'hDEAD);
            chk(wr_stb_lo == '0 && wr_stb_hi == '0, "R2 memory write", {wr_stb_lo, wr_stb_hi}, 0);
            check_latches("R2 memory write hold");
            drive(0, 0, 1, {4'h0, BASE + 16'(2 * p)}, 0, 16'hBEEF);
            chk(wr_stb_lo == '0 && wr_stb_hi == '0, "R2 idle write", {wr_stb_lo, wr_stb_hi}, 0);
            check_latches("R2 idle write hold");
            drive(1, 1, 0, {4'h0, BASE + 16'(2 * p)}, 1, 16'h0);
            chk(rd_oe == 1'b0 && rd_data == 16'h0, "R2 memory read", {rd_oe, rd_data}, 0);
        end

        // Window sweep for reads and writes: R7, R8, R9, R1.
        for (int off = -6; off < 2 * NP + 6; off++) begin
            for (int v = 0; v < 4; v++) begin
                logic [15:0]   a16;
                logic          inr;
                logic [15:0]   exp_d;
                logic [AW-1:0] a;
                a16 = BASE + 16'(off);
                inr = (off >= 0) && (off < 2 * NP);
                exp_d = inr ? in_word(off / 2) : 16'h0;
                a = {4'(v * 5 + off), a16};
                drive(1, 0, 0, a, v[0], 16'hFFFF);
                chk(rd_oe == inr, "R7 R9 read enable", rd_oe, inr);
                chk(rd_data == exp_d, "R7 R8 read data", rd_data, exp_d);
                chk(wr_stb_lo == '0 && wr_stb_hi == '0, "R2 no strobe on read",
                    {wr_stb_lo, wr_stb_hi}, 0);
                if (!inr) begin
                    drive(1, 0, 1, a, 1'b0, 16'h5A5A);
                    chk(wr_stb_lo == '0 && wr_stb_hi == '0, "R9 out of range write",
                        {wr_stb_lo, wr_stb_hi}, 0);
                    check_latches("R9 out of range hold");
                end
            end
        end

        // R10: reset in the middle clears latches written above.
        @(negedge clk);
        cyc_act = 0;
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        chk(out_ports == '0, "R10 reset clears", out_ports, 0);

        done = 1'b1;
        finish_run();
    end
endmodule